// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block sits between a serial character assembler and a CPU read port. Each completed character arrives with a one-cycle valid strobe and two error flags: parity and framing. The block stores the character in a short queue. Each slot holds the data and its own error flags, and both are written on the same edge. The CPU sees the oldest character and a status word. A read strobe removes that oldest character.

The status word combines three kinds of error reporting:
- Parity errors and overruns are sticky: once a flagged character has been at the head, the bit stays set until the CPU issues an error-reset command.
- Framing errors are reported only for the character currently at the head.
- When a character completes while every slot is still occupied, it replaces the newest stored character, and only that replacement carries the overrun mark.

A special-receive interrupt request is raised from the head character's flags. A second output tells the vector logic to select the special-receive vector when status-affects-vector is enabled.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the queue is empty: `charAvail` is 0, `rdData` is 0, `statusWord` is 8'h00, and `specialIrq` and `vecSpecial` are 0.
- R2: Characters are read in arrival order. `rdData` shows the head character while the queue is non-empty and 0 while it is empty. A `rdPop` high at a clock edge removes the head.
- R3: `charAvail` and `statusWord` bit 0 are 1 exactly when at least one character is stored. The queue holds `DEPTH` (default 3) characters.
- R4: When `charValid` arrives with `DEPTH` characters stored and no pop on that edge, the new character replaces the newest stored one, and the older characters are unchanged. The overrun flag is set on that replaced slot only.
- R5: `statusWord` bit 5 (overrun) is 1 while the head carries the overrun flag. It stays 1 after that character is popped, until `errReset`.
- R6: `statusWord` bit 4 (parity) is 1 while the head carries a parity flag. It stays 1 after that character is popped, until `errReset`.
- R7: `statusWord` bit 6 (framing) equals the head character's framing flag, is 0 when the queue is empty, and is never sticky.
- R8: `errReset` clears the sticky parity and overrun bits, and clears the parity and overrun flags of the current head. Framing flags and data are unaffected.
- R9: `specialIrq` is 1 when the head has a framing or overrun flag, or a parity flag while `parityIsSpecial` is 1. `vecSpecial` is `specialIrq` AND `statusVecEnable`.
- R10: A push and a pop on the same edge, including when the queue is full, lose and duplicate nothing, and set no overrun.
- R11: A `rdPop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | Assembled character valid strobe |
| charData | input | DATA_W | Assembled character |
| charParityErr | input | 1 | Parity error of the incoming character |
| charFrameErr | input | 1 | Framing error of the incoming character |
| rdPop | input | 1 | CPU read strobe; pops the head |
| errReset | input | 1 | Error-reset command |
| parityIsSpecial | input | 1 | Parity errors raise the special-receive condition |
| statusVecEnable | input | 1 | Status-affects-vector enable |
| rdData | output | DATA_W | Head character |
| statusWord | output | 8 | Bit 0 available, bit 4 parity, bit 5 overrun, bit 6 framing |
| charAvail | output | 1 | Queue not empty |
| specialIrq | output | 1 | Special-receive interrupt request |
| vecSpecial | output | 1 | Select the special-receive vector |

## Verification
The bench builds the block with the defaults DATA_W = 8 and DEPTH = 3. With only three slots, a handful of strobes reaches every fill level. That includes the full state, where the overwrite path, simultaneous push-and-pop, and error reset combine, so a long mixed stimulus crosses all of them many times. Eight-bit data keeps each character distinct, so reordering or loss shows up directly in `rdData`.

// File: rtl/rx_char_queue_pkg.sv
package rx_char_queue_pkg;
  localparam int STATUS_W  = 8;
  localparam int AVAIL_BIT = 0;
  localparam int PAR_BIT   = 4;
  localparam int OVR_BIT   = 5;
  localparam int FRM_BIT   = 6;

  typedef struct packed {
    logic parityErr;
    logic frameErr;
    logic overrun;
  } errFlags_t;

  typedef struct packed {
    logic push;       // append at first free slot after shift
    logic pop;        // remove head
    logic overwrite;  // replace newest slot, mark overrun
    logic clearErr;   // error-reset command
  } qStrobe_t;
endpackage

// File: rtl/rx_char_queue_ctrl.sv
module rx_char_queue_ctrl
  import rx_char_queue_pkg::*;
(
  input  logic     headValid,
  input  logic     full,
  input  logic     charValid,
  input  logic     rdPop,
  input  logic     errReset,
  output qStrobe_t strobe
);
  logic popOk;

  assign popOk = rdPop & headValid;

  always_comb begin
    strobe           = '0;
    strobe.pop       = popOk;
    strobe.push      = charValid & (~full | popOk);
    strobe.overwrite = charValid & full & ~popOk;
    strobe.clearErr  = errReset;
  end
endmodule

// File: rtl/rx_char_queue_dp.sv
module rx_char_queue_dp
  import rx_char_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  qStrobe_t            strobe,
  input  logic [DATA_W-1:0]   charData,
  input  logic                charParityErr,
  input  logic                charFrameErr,
  input  logic                parityIsSpecial,
  input  logic                statusVecEnable,
  output logic                headValid,
  output logic                full,
  output logic [DATA_W-1:0]   rdData,
  output logic [STATUS_W-1:0] statusWord,
  output logic                specialIrq,
  output logic                vecSpecial
);
  localparam int TOP = DEPTH - 1;

  logic [DEPTH-1:0]  valQ, shVal, wrHere, nxtVal;
  logic [DATA_W-1:0] dataQ   [DEPTH];
  logic [DATA_W-1:0] nxtData [DEPTH];
  errFlags_t         flgQ    [DEPTH];
  errFlags_t         nxtFlg  [DEPTH];
  errFlags_t         inFlg, ovrFlg, headFlg;
  logic              stickyPar, stickyOvr;

  assign inFlg  = '{parityErr: charParityErr, frameErr: charFrameErr, overrun: 1'b0};
  assign ovrFlg = '{parityErr: charParityErr, frameErr: charFrameErr, overrun: 1'b1};

  // Head flags after an error-reset command (discarded if popped).
  always_comb begin
    headFlg = flgQ[0];
    if (strobe.clearErr) begin
      headFlg.parityErr = 1'b0;
      headFlg.overrun   = 1'b0;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] shData;
    errFlags_t         ownFlg, shFlg;
    logic              lowerOcc, overHere;

    if (i == 0) begin : g_head
      assign ownFlg   = headFlg;
      assign lowerOcc = 1'b1;
    end else begin : g_body
      assign ownFlg   = flgQ[i];
      assign lowerOcc = shVal[i-1];
    end

    if (i < TOP) begin : g_mid
      assign shVal[i] = strobe.pop ? valQ[i+1]  : valQ[i];
      assign shData   = strobe.pop ? dataQ[i+1] : dataQ[i];
      assign shFlg    = strobe.pop ? flgQ[i+1]  : ownFlg;
      assign overHere = 1'b0;
    end else begin : g_top
      assign shVal[i] = strobe.pop ? 1'b0 : valQ[i];
      assign shData   = strobe.pop ? '0   : dataQ[i];
      assign shFlg    = strobe.pop ? '0   : ownFlg;
      assign overHere = strobe.overwrite;
    end

    assign wrHere[i]  = strobe.push & ~shVal[i] & lowerOcc;
    assign nxtVal[i]  = shVal[i] | wrHere[i] | overHere;
    assign nxtData[i] = (wrHere[i] | overHere) ? charData : shData;
    assign nxtFlg[i]  = wrHere[i] ? inFlg : (overHere ? ovrFlg : shFlg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valQ <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        dataQ[k] <= '0;
        flgQ[k]  <= '0;
      end
    end else begin
      valQ <= nxtVal;
      for (int k = 0; k < DEPTH; k++) begin
        dataQ[k] <= nxtData[k];
        flgQ[k]  <= nxtFlg[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearErr) begin
      stickyPar <= 1'b0;
      stickyOvr <= 1'b0;
    end else begin
      stickyPar <= stickyPar | (strobe.pop & flgQ[0].parityErr);
      stickyOvr <= stickyOvr | (strobe.pop & flgQ[0].overrun);
    end
  end

  assign headValid = valQ[0];
  assign full      = valQ[TOP];
  assign rdData    = valQ[0] ? dataQ[0] : '0;

  always_comb begin
    statusWord            = '0;
    statusWord[AVAIL_BIT] = valQ[0];
    statusWord[PAR_BIT]   = stickyPar | (valQ[0] & flgQ[0].parityErr);
    statusWord[OVR_BIT]   = stickyOvr | (valQ[0] & flgQ[0].overrun);
    statusWord[FRM_BIT]   = valQ[0] & flgQ[0].frameErr;
  end

  assign specialIrq = valQ[0] & (flgQ[0].frameErr | flgQ[0].overrun |
                                 (parityIsSpecial & flgQ[0].parityErr));
  assign vecSpecial = specialIrq & statusVecEnable;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rx_char_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                charValid,
  input  logic [DATA_W-1:0]   charData,
  input  logic                charParityErr,
  input  logic                charFrameErr,
  input  logic                rdPop,
  input  logic                errReset,
  input  logic                parityIsSpecial,
  input  logic                statusVecEnable,
  output logic [DATA_W-1:0]   rdData,
  output logic [STATUS_W-1:0] statusWord,
  output logic                charAvail,
  output logic                specialIrq,
  output logic                vecSpecial
);
  qStrobe_t strobe;
  logic     headValid, full;

  rx_char_queue_ctrl u_ctrl (
    .headValid (headValid),
    .full      (full),
    .charValid (charValid),
    .rdPop     (rdPop),
    .errReset  (errReset),
    .strobe    (strobe)
  );

  rx_char_queue_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .charData        (charData),
    .charParityErr   (charParityErr),
    .charFrameErr    (charFrameErr),
    .parityIsSpecial (parityIsSpecial),
    .statusVecEnable (statusVecEnable),
    .headValid       (headValid),
    .full            (full),
    .rdData          (rdData),
    .statusWord      (statusWord),
    .specialIrq      (specialIrq),
    .vecSpecial      (vecSpecial)
  );

  assign charAvail = headValid;
endmodule

// File: rtl/rx_char_queue_chk.sv
module rx_char_queue_chk
  import rx_char_queue_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                charValid,
  input logic                rdPop,
  input logic                errReset,
  input logic                statusVecEnable,
  input logic [STATUS_W-1:0] statusWord,
  input logic                charAvail,
  input logic                specialIrq,
  input logic                vecSpecial
);
  a_r1_empty_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    !charAvail |-> !specialIrq);

  a_r9_vec_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    vecSpecial |-> (specialIrq && statusVecEnable));

  a_r7_frame_needs_char: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[FRM_BIT] |-> charAvail);

  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[OVR_BIT] && !errReset) |=> statusWord[OVR_BIT]);

  a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[PAR_BIT] && !errReset) |=> statusWord[PAR_BIT]);

  a_r8_reset_clears_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (errReset && !rdPop) |=> !statusWord[OVR_BIT]);

  a_r8_reset_clears_par: assert property (@(posedge clk) disable iff (!rstN)
    (errReset && !rdPop && !(charValid && !charAvail)) |=> !statusWord[PAR_BIT]);

  a_r10_rw_keeps_char: assert property (@(posedge clk) disable iff (!rstN)
    (charAvail && rdPop && charValid) |=> charAvail);

  a_r11_idle_stays_empty: assert property (@(posedge clk) disable iff (!rstN)
    (!charAvail && !charValid) |=> !charAvail);
endmodule

bind rx_char_queue rx_char_queue_chk u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .charValid       (charValid),
  .rdPop           (rdPop),
  .errReset        (errReset),
  .statusVecEnable (statusVecEnable),
  .statusWord      (statusWord),
  .charAvail       (charAvail),
  .specialIrq      (specialIrq),
  .vecSpecial      (vecSpecial)
);

// File: tb/rx_char_queue_bench.sv
`timescale 1ns/1ps
module rx_char_queue_bench;
  localparam int DW = 8;
  localparam int D  = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          charValid = 0, charParityErr = 0, charFrameErr = 0;
  logic [DW-1:0] charData = '0;
  logic          rdPop = 0, errReset = 0, parityIsSpecial = 0, statusVecEnable = 0;
  logic [DW-1:0] rdData;
  logic [7:0]    statusWord;
  logic          charAvail, specialIrq, vecSpecial;

  rx_char_queue #(.DATA_W(DW), .DEPTH(D)) u_rx_char_queue (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charParityErr(charParityErr), .charFrameErr(charFrameErr),
    .rdPop(rdPop), .errReset(errReset), .parityIsSpecial(parityIsSpecial),
    .statusVecEnable(statusVecEnable), .rdData(rdData), .statusWord(statusWord),
    .charAvail(charAvail), .specialIrq(specialIrq), .vecSpecial(vecSpecial)
  );

  int nChecks = 0;
  int nErr    = 0;

  // Reference model, built from the requirements.
  logic [DW-1:0] mData [D];
  logic          mP [D], mF [D], mO [D];
  int            mCnt = 0;
  logic          sP = 0, sO = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic doPop;
    doPop = rdPop && (mCnt > 0);
    if (!errReset && doPop) begin
      sP = sP | mP[0];
      sO = sO | mO[0];
    end
    if (errReset) begin           // R8
      sP = 0; sO = 0; mP[0] = 0; mO[0] = 0;
    end
    if (doPop) begin
      for (int k = 0; k < D-1; k++) begin
        mData[k] = mData[k+1]; mP[k] = mP[k+1]; mF[k] = mF[k+1]; mO[k] = mO[k+1];
      end
      mCnt--;
    end
    if (charValid) begin
      if (mCnt < D) begin
        mData[mCnt] = charData; mP[mCnt] = charParityErr;
        mF[mCnt] = charFrameErr; mO[mCnt] = 0; mCnt++;
      end else begin              // R4 overwrite newest
        mData[D-1] = charData; mP[D-1] = charParityErr;
        mF[D-1] = charFrameErr; mO[D-1] = 1;
      end
    end
  endtask

  task automatic compareModel();
    logic av, ep, eo, ef, irq;
    logic [7:0] st;
    av  = (mCnt > 0);
    ep  = sP | (av & mP[0]);
    eo  = sO | (av & mO[0]);
    ef  = av & mF[0];
    st  = {1'b0, ef, eo, ep, 3'b000, av};
    irq = av & (mF[0] | mO[0] | (parityIsSpecial & mP[0]));
    chk("R3 avail", charAvail, av);
    chk("R2 data", rdData, av ? mData[0] : '0);
    chk("R6 parity bit", statusWord[4], ep);
    chk("R5 overrun bit", statusWord[5], eo);
    chk("R7 framing bit", statusWord[6], ef);
    chk("R3 status word", statusWord, st);
    chk("R9 irq", specialIrq, irq);
    chk("R9 vector", vecSpecial, irq & statusVecEnable);
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic pe,
                      input logic fe, input logic pop, input logic er);
    charValid = v; charData = d; charParityErr = pe; charFrameErr = fe;
    rdPop = pop; errReset = er;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    charValid = 0; rdPop = 0; errReset = 0;
    compareModel();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    for (int k = 0; k < D; k++) begin mData[k] = 0; mP[k] = 0; mF[k] = 0; mO[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 avail", charAvail, 0);
    chk("R1 data", rdData, 0);
    chk("R1 status", statusWord, 8'h00);
    chk("R1 irq", {specialIrq, vecSpecial}, 2'b00);

    // R4 / R5 / R7 overwrite path
    statusVecEnable = 1;
    step(1, 8'hA1, 0, 0, 0, 0);
    step(1, 8'hB2, 0, 0, 0, 0);
    step(1, 8'hC3, 0, 0, 0, 0);
    chk("R2 head first", rdData, 8'hA1);
    chk("R3 status full", statusWord, 8'h01);
    step(1, 8'hD4, 0, 1, 0, 0);
    chk("R4 head untouched", rdData, 8'hA1);
    chk("R4 no overrun on older head", statusWord[5], 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R4 second kept", rdData, 8'hB2);
    step(0, 0, 0, 0, 1, 0);
    chk("R4 replaced newest", rdData, 8'hD4);
    chk("R4 overrun+framing on replaced", statusWord, 8'h61);
    chk("R9 irq on overrun", {specialIrq, vecSpecial}, 2'b11);
    step(0, 0, 0, 0, 1, 0);
    chk("R5 sticky overrun after pop, R7 framing gone", statusWord, 8'h20);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 reset clears", statusWord, 8'h00);

    // R6 / R9 / R8 parity
    step(1, 8'h55, 1, 0, 0, 0);
    chk("R6 parity shown", statusWord, 8'h11);
    chk("R9 parity not special", specialIrq, 0);
    parityIsSpecial = 1;
    #1;
    chk("R9 parity special", {specialIrq, vecSpecial}, 2'b11);
    statusVecEnable = 0;
    #1;
    chk("R9 vector disabled", {specialIrq, vecSpecial}, 2'b10);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 head parity cleared", statusWord, 8'h01);
    chk("R8 data kept", rdData, 8'h55);
    chk("R8 irq dropped", specialIrq, 0);

    // R11 pop on empty
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R11 still empty", {charAvail, statusWord}, 9'h000);
    step(1, 8'h66, 0, 0, 0, 0);
    chk("R11 next push is head", rdData, 8'h66);
    step(0, 0, 0, 0, 1, 0);

    // R10 simultaneous push and pop when full
    step(1, 8'h01, 0, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0, 0);
    step(1, 8'h03, 0, 0, 0, 0);
    step(1, 8'h04, 0, 0, 1, 0);
    chk("R10 head advanced", rdData, 8'h02);
    chk("R10 no overrun", statusWord, 8'h01);
    step(0, 0, 0, 0, 1, 0);
    chk("R10 order 3", rdData, 8'h03);
    step(0, 0, 0, 0, 1, 0);
    chk("R10 order 4", rdData, 8'h04);
    step(0, 0, 0, 0, 1, 0);
    chk("R10 drained", charAvail, 0);

    // Mixed sweep over fill levels, flags and commands.
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (n % 64 == 0) begin
        parityIsSpecial = r[20];
        statusVecEnable = r[21];
      end
      step(r[0] | r[1], r[15:8], r[2], r[3] & r[4], r[5] & ~r[6], r[7] & r[16] & r[17]);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule